// File: doc/BRIEF.md
# Iterative AES-128 Cipher Core

This block encrypts or decrypts a single 128-bit block under a 128-bit key. It follows the standard AES-128 algorithm with 10 rounds. The datapath is folded so that it performs one round transformation per clock. The caller presents a key, a data block and a direction bit together with a one-cycle start pulse. Some cycles later the result appears on a registered output, and a one-cycle done pulse marks it.

Round keys are never stored as a full schedule. Encryption derives each round key from the previous one while the rounds run. Decryption needs the last round key as its starting point, and then walks the schedule backwards one key per cycle. The core keeps the last round key of the most recently expanded key, together with that key. A decryption under the same key therefore starts at once. A decryption under any other key first spends ten cycles expanding the schedule forward.

Top module: `aes128_iter_core`

## Requirements
- R1: An encryption produces the AES-128 ciphertext of `block_i` under `key_i`. Byte 0 of every block and key sits in bits [127:120], and bytes fill the state column by column.
- R2: A decryption (`decrypt_i`=1) produces the AES-128 plaintext of `block_i` under `key_i`, using the same byte mapping.
- R3: An encryption accepted at clock edge n updates `block_o` and raises `done_o` at edge n+10, so the work spans exactly 11 edges.
- R4: A decryption whose key equals the key of the most recently started encryption or key expansion (since reset) also completes at edge n+10.
- R5: A decryption under any other key, or the first decryption after reset, completes at edge n+20.
- R6: `done_o` is high for exactly one cycle per completed block.
- R7: `block_o` changes only in the cycle that `done_o` is high. It holds its value in all other cycles.
- R8: A start pulse that arrives while a block is in progress is ignored. It causes no extra done pulse and does not alter the running block's result or timing.
- R9: `key_i`, `block_i` and `decrypt_i` are sampled only at the accepting edge. Changing them later has no effect on the result.
- R10: After a synchronous reset, `block_o` is zero, `done_o` is low and no key is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a block when idle |
| decrypt_i | input | 1 | 1 selects decryption, 0 selects encryption |
| key_i | input | 128 | Cipher key, byte 0 in the top bits |
| block_i | input | 128 | Plaintext or ciphertext block |
| block_o | output | 128 | Result of the last completed block |
| done_o | output | 1 | One-cycle pulse when `block_o` is updated |

## Verification
The assertions assume that reset is held low for at least two clock edges. This makes the stability and pulse checks start from the reset values and not from unknown ones. They place no constraint on `start_i`, which may rise in any cycle, including while the core is busy. Their latency check accepts only the two legal completion distances.

The stimulus drives all inputs on falling edges. It mixes isolated starts with starts issued in the very cycle that `done_o` is high. It scrambles the key, data and direction inputs, and adds a stray start, in the middle of both a round phase and a key-expansion phase. All expected results come from published AES-128 vectors.

// File: rtl/aes128_pkg.sv
// Package aes128_pkg
// Shared constants, phase type and byte-level arithmetic for the AES-128 core.
// The S-box is computed from the multiplicative inverse in GF(2^8) followed by
// the affine map, so no substitution table is written out.
package aes128_pkg;

    localparam int BLOCK_W    = 128;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int NB_BYTES   = BLOCK_W / BYTE_W;
    localparam int NB_COLS    = BLOCK_W / WORD_W;
    localparam int NUM_ROUNDS = 10;
    localparam int RND_W      = $clog2(NUM_ROUNDS + 1);
    localparam int LAT_W      = $clog2(2 * NUM_ROUNDS + 1);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_EXPAND = 2'd1,
        PH_ENC    = 2'd2,
        PH_DEC    = 2'd3
    } phase_t;

    // multiply by x modulo the AES polynomial
    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // general GF(2^8) product
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // inverse as x^254 (zero maps to zero)
    function automatic logic [7:0] ginv(input logic [7:0] x);
        logic [7:0] p;
        p = gmul(x, x);          // x^2
        p = gmul(p, x);          // x^3
        p = gmul(p, p);          // x^6
        p = gmul(p, x);          // x^7
        p = gmul(p, p);          // x^14
        p = gmul(p, x);          // x^15
        p = gmul(p, p);          // x^30
        p = gmul(p, x);          // x^31
        p = gmul(p, p);          // x^62
        p = gmul(p, x);          // x^63
        p = gmul(p, p);          // x^126
        p = gmul(p, x);          // x^127
        p = gmul(p, p);          // x^254
        return p;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        logic [15:0] d;
        d = {v, v} << n;
        return d[15:8];
    endfunction

    function automatic logic [7:0] sbox(input logic [7:0] x);
        logic [7:0] v;
        v = ginv(x);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] inv_sbox(input logic [7:0] x);
        return ginv(rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05);
    endfunction

    // round constant for round r (1..10)
    function automatic logic [7:0] rcon(input logic [RND_W-1:0] r);
        logic [7:0] c;
        c = 8'h01;
        for (int i = 1; i < NUM_ROUNDS; i++) begin
            if (i < int'(r)) c = xtime(c);
        end
        return c;
    endfunction

    // rotate a key word left by one byte and substitute each byte
    function automatic logic [WORD_W-1:0] rot_sub(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        r = {w[23:0], w[31:24]};
        return {sbox(r[31:24]), sbox(r[23:16]), sbox(r[15:8]), sbox(r[7:0])};
    endfunction

    function automatic logic [WORD_W-1:0] mix_col(input logic [WORD_W-1:0] c);
        logic [7:0] a0, a1, a2, a3;
        {a0, a1, a2, a3} = c;
        return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
                a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
                a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
                xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
    endfunction

    function automatic logic [WORD_W-1:0] inv_mix_col(input logic [WORD_W-1:0] c);
        logic [7:0] a0, a1, a2, a3;
        {a0, a1, a2, a3} = c;
        return {gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09),
                gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d),
                gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b),
                gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e)};
    endfunction

endpackage

// File: rtl/aes128_key_step.sv
// Module aes128_key_step
// One step of the AES-128 key schedule in both directions, purely combinational.
// next_o is round key rnd_i computed from round key rnd_i-1 held in key_i.
// prev_o is round key rnd_i-1 recovered from round key rnd_i held in key_i.
// Assumes rnd_i lies in 1..10; word 0 occupies the top 32 bits.
module aes128_key_step
    import aes128_pkg::*;
(
    input  logic [BLOCK_W-1:0] key_i,
    input  logic [RND_W-1:0]   rnd_i,
    output logic [BLOCK_W-1:0] next_o,
    output logic [BLOCK_W-1:0] prev_o
);

    logic [WORD_W-1:0] w   [NB_COLS];
    logic [WORD_W-1:0] nw  [NB_COLS];
    logic [WORD_W-1:0] pw  [NB_COLS];
    logic [WORD_W-1:0] rc_word;

    assign rc_word = {rcon(rnd_i), 24'h000000};

    for (genvar i = 0; i < NB_COLS; i++) begin : g_split
        assign w[i] = key_i[BLOCK_W-1-WORD_W*i -: WORD_W];
        assign next_o[BLOCK_W-1-WORD_W*i -: WORD_W] = nw[i];
        assign prev_o[BLOCK_W-1-WORD_W*i -: WORD_W] = pw[i];
    end

    // forward chain: each word folds in the freshly computed word before it
    assign nw[0] = w[0] ^ rot_sub(w[3]) ^ rc_word;
    for (genvar i = 1; i < NB_COLS; i++) begin : g_fwd
        assign nw[i] = w[i] ^ nw[i-1];
    end

    // backward chain: undo the xor chain, then the substituted word
    for (genvar i = 1; i < NB_COLS; i++) begin : g_bwd
        assign pw[i] = w[i] ^ w[i-1];
    end
    assign pw[0] = w[0] ^ rot_sub(pw[3]) ^ rc_word;

endmodule

// File: rtl/aes128_enc_round.sv
// Module aes128_enc_round
// One forward AES round: SubBytes, ShiftRows, MixColumns (skipped when
// final_i is high) and AddRoundKey. Combinational. Byte b of the state is
// row b%4, column b/4, and sits at bits [127-8b -: 8].
module aes128_enc_round
    import aes128_pkg::*;
(
    input  logic [BLOCK_W-1:0] state_i,
    input  logic [BLOCK_W-1:0] rkey_i,
    input  logic               final_i,
    output logic [BLOCK_W-1:0] state_o
);

    logic [BYTE_W-1:0] sub_b [NB_BYTES];
    logic [BYTE_W-1:0] shf_b [NB_BYTES];
    logic [BYTE_W-1:0] mix_b [NB_BYTES];

    for (genvar b = 0; b < NB_BYTES; b++) begin : g_byte
        localparam int ROW = b % 4;
        localparam int COL = b / 4;
        assign sub_b[b] = sbox(state_i[BLOCK_W-1-BYTE_W*b -: BYTE_W]);
        // row r is rotated left by r columns
        assign shf_b[b] = sub_b[ROW + 4 * ((COL + ROW) % NB_COLS)];
        assign state_o[BLOCK_W-1-BYTE_W*b -: BYTE_W] =
            (final_i ? shf_b[b] : mix_b[b]) ^ rkey_i[BLOCK_W-1-BYTE_W*b -: BYTE_W];
    end

    for (genvar c = 0; c < NB_COLS; c++) begin : g_col
        assign {mix_b[4*c], mix_b[4*c+1], mix_b[4*c+2], mix_b[4*c+3]} =
            mix_col({shf_b[4*c], shf_b[4*c+1], shf_b[4*c+2], shf_b[4*c+3]});
    end

endmodule

// File: rtl/aes128_dec_round.sv
// Module aes128_dec_round
// One inverse AES round in the straight inverse-cipher order:
// InvShiftRows, InvSubBytes, AddRoundKey, then InvMixColumns unless
// final_i is high. Combinational; same byte mapping as the forward round.
module aes128_dec_round
    import aes128_pkg::*;
(
    input  logic [BLOCK_W-1:0] state_i,
    input  logic [BLOCK_W-1:0] rkey_i,
    input  logic               final_i,
    output logic [BLOCK_W-1:0] state_o
);

    logic [BYTE_W-1:0] shf_b [NB_BYTES];
    logic [BYTE_W-1:0] ark_b [NB_BYTES];
    logic [BYTE_W-1:0] mix_b [NB_BYTES];

    for (genvar b = 0; b < NB_BYTES; b++) begin : g_byte
        localparam int ROW = b % 4;
        localparam int COL = b / 4;
        localparam int SRC = ROW + 4 * ((COL + NB_COLS - ROW) % NB_COLS);
        // row r is rotated right by r columns
        assign shf_b[b] = state_i[BLOCK_W-1-BYTE_W*SRC -: BYTE_W];
        assign ark_b[b] = inv_sbox(shf_b[b]) ^ rkey_i[BLOCK_W-1-BYTE_W*b -: BYTE_W];
        assign state_o[BLOCK_W-1-BYTE_W*b -: BYTE_W] = final_i ? ark_b[b] : mix_b[b];
    end

    for (genvar c = 0; c < NB_COLS; c++) begin : g_col
        assign {mix_b[4*c], mix_b[4*c+1], mix_b[4*c+2], mix_b[4*c+3]} =
            inv_mix_col({ark_b[4*c], ark_b[4*c+1], ark_b[4*c+2], ark_b[4*c+3]});
    end

endmodule

// File: rtl/aes128_iter_core.sv
// Module aes128_iter_core
// Round-per-clock AES-128 encrypt/decrypt core. An accepted start applies the
// initial AddRoundKey; ten further edges apply rounds 1..10. Decryption starts
// from the last round key, taken from a one-entry memory when the key matches,
// or else produced by a ten-edge forward expansion phase.
// Assumes: start_i is honoured only when idle; reset is held for two or more edges.
module aes128_iter_core
    import aes128_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               decrypt_i,
    input  logic [BLOCK_W-1:0] key_i,
    input  logic [BLOCK_W-1:0] block_i,
    output logic [BLOCK_W-1:0] block_o,
    output logic               done_o
);

    localparam logic [RND_W-1:0] LAST_RND  = RND_W'(NUM_ROUNDS);
    localparam logic [RND_W-1:0] FIRST_RND = RND_W'(1);

    phase_t             phase_q;
    logic [RND_W-1:0]   cnt_q;
    logic [BLOCK_W-1:0] st_q;
    logic [BLOCK_W-1:0] rk_q;
    logic [BLOCK_W-1:0] tag_q;
    logic [BLOCK_W-1:0] last_rk_q;
    logic               mem_ok_q;
    logic [BLOCK_W-1:0] out_q;
    logic               done_q;

    logic               accept;
    logic               last_step;
    logic               finish;
    logic               mem_hit;
    logic [RND_W-1:0]   key_rnd;
    logic [BLOCK_W-1:0] key_next;
    logic [BLOCK_W-1:0] key_prev;
    logic [BLOCK_W-1:0] enc_out;
    logic [BLOCK_W-1:0] dec_out;

    assign accept    = (phase_q == PH_IDLE) && start_i;
    assign last_step = (cnt_q == LAST_RND);
    assign finish    = ((phase_q == PH_ENC) || (phase_q == PH_DEC)) && last_step;
    assign mem_hit   = mem_ok_q && (key_i == tag_q);
    // backward walk needs the constant of the round whose key is held
    assign key_rnd   = (phase_q == PH_DEC) ? RND_W'(NUM_ROUNDS + 1 - int'(cnt_q)) : cnt_q;

    aes128_key_step u_key_step (
        .key_i  (rk_q),
        .rnd_i  (key_rnd),
        .next_o (key_next),
        .prev_o (key_prev)
    );

    aes128_enc_round u_enc_round (
        .state_i (st_q),
        .rkey_i  (key_next),
        .final_i (last_step),
        .state_o (enc_out)
    );

    aes128_dec_round u_dec_round (
        .state_i (st_q),
        .rkey_i  (key_prev),
        .final_i (last_step),
        .state_o (dec_out)
    );

    // Phase sequencing and round counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        cnt_q <= FIRST_RND;
                        if (!decrypt_i)   phase_q <= PH_ENC;
                        else if (mem_hit) phase_q <= PH_DEC;
                        else              phase_q <= PH_EXPAND;
                    end
                end
                PH_EXPAND: begin
                    if (last_step) begin
                        phase_q <= PH_DEC;
                        cnt_q   <= FIRST_RND;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_ENC, PH_DEC: begin
                    if (last_step) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Cipher state and working round key
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            rk_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        if (!decrypt_i) begin
                            st_q <= block_i ^ key_i;
                            rk_q <= key_i;
                        end else if (mem_hit) begin
                            st_q <= block_i ^ last_rk_q;
                            rk_q <= last_rk_q;
                        end else begin
                            st_q <= block_i;
                            rk_q <= key_i;
                        end
                    end
                end
                PH_EXPAND: begin
                    rk_q <= key_next;
                    if (last_step) st_q <= st_q ^ key_next;
                end
                PH_ENC: begin
                    st_q <= enc_out;
                    rk_q <= key_next;
                end
                PH_DEC: begin
                    st_q <= dec_out;
                    rk_q <= key_prev;
                end
                default: ;
            endcase
        end
    end

    // One-entry memory of the last expanded key and its final round key
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q     <= '0;
            last_rk_q <= '0;
            mem_ok_q  <= 1'b0;
        end else if (accept && !(decrypt_i && mem_hit)) begin
            tag_q    <= key_i;
            mem_ok_q <= mem_hit;
        end else if (((phase_q == PH_ENC) || (phase_q == PH_EXPAND)) && last_step) begin
            last_rk_q <= key_next;
            mem_ok_q  <= 1'b1;
        end
    end

    // Result register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) out_q <= (phase_q == PH_ENC) ? enc_out : dec_out;
        end
    end

    assign block_o = out_q;
    assign done_o  = done_q;

    // Edges since the accepting edge, kept for the latency assertion only
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  lat_q <= '0;
        else if (accept)             lat_q <= '0;
        else if (phase_q != PH_IDLE) lat_q <= lat_q + 1'b1;
    end

    // R3 R4 R5: completion only 10 or 20 edges after acceptance
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((lat_q == LAT_W'(NUM_ROUNDS)) || (lat_q == LAT_W'(2 * NUM_ROUNDS))));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(block_o));

    a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |-> ((cnt_q >= FIRST_RND) && (cnt_q <= LAST_RND)));

    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q != PH_IDLE) && start_i && !last_step) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: tb/aes128_iter_core_tb.sv
module aes128_iter_core_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         decrypt_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [127:0] block_i = '0;
    logic [127:0] block_o;
    logic         done_o;

    always #5 clk = ~clk;

    aes128_iter_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .decrypt_i (decrypt_i),
        .key_i     (key_i),
        .block_i   (block_i),
        .block_o   (block_o),
        .done_o    (done_o)
    );

    typedef struct {
        logic [127:0] exp;
        int           lat;
        int           start_edge;
        string        res_tag;
        string        lat_tag;
    } item_t;

    item_t        sb [$];
    int           n_chk = 0;
    int           n_fail = 0;
    int           cyc = 0;
    logic [127:0] last_out = '0;
    logic         prev_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk128(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pop and compare on each done pulse; watch pulse width and holding
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                if (sb.size() == 0) begin
                    chk_int("R8 unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk128(it.res_tag, block_o, it.exp);
                    chk_int(it.lat_tag, cyc - it.start_edge, it.lat);
                end
            end
            if (prev_done && done_o) chk_int("R6 done wider than one cycle", 2, 1);
            if (!done_o && (block_o !== last_out)) chk128("R7 result changed without done", block_o, last_out);
        end
        prev_done = done_o;
        last_out  = block_o;
    end

    // Driver: launch one block and push its expectation
    task automatic run(input logic [127:0] k, input logic [127:0] d, input logic dec,
                       input logic [127:0] exp, input int lat,
                       input string res_tag, input string lat_tag,
                       input bit b2b, input bit poke);
        item_t it;
        if (b2b) begin
            do @(negedge clk); while (!done_o);
        end else begin
            while (sb.size() != 0) @(negedge clk);
            @(negedge clk);
        end
        key_i     = k;
        block_i   = d;
        decrypt_i = dec;
        start_i   = 1'b1;
        it.exp = exp; it.lat = lat; it.start_edge = cyc + 1;
        it.res_tag = res_tag; it.lat_tag = lat_tag;
        sb.push_back(it);
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R9: scramble inputs after acceptance; R8: stray start while busy
            key_i     = ~k;
            block_i   = ~d;
            decrypt_i = ~dec;
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    localparam logic [127:0] K_SEQ  = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] K_STD  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] K_ZERO = 128'h0;

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk128("R10 block_o after reset", block_o, 128'h0);
        chk_int("R10 done_o after reset", int'(done_o), 0);
        rst_n = 1'b1;

        run(K_SEQ, 128'h00112233445566778899aabbccddeeff, 1'b0,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a, 10, "R1 enc", "R3 enc latency", 1'b0, 1'b0);
        run(K_SEQ, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b1,
            128'h00112233445566778899aabbccddeeff, 10, "R2 dec", "R4 dec same key", 1'b0, 1'b0);
        run(K_STD, 128'h3925841d02dc09fbdc118597196a0b32, 1'b1,
            128'h3243f6a8885a308d313198a2e0370734, 20, "R2 dec", "R5 dec new key", 1'b0, 1'b0);
        run(K_STD, 128'h3ad77bb40d7a3660a89ecaf32466ef97, 1'b1,
            128'h6bc1bee22e409f96e93d7e117393172a, 10, "R2 dec back-to-back", "R4 dec same key", 1'b1, 1'b0);
        run(K_STD, 128'hae2d8a571e03ac9c9eb76fac45af8e51, 1'b0,
            128'hf5d3d58503b9699de785895a96fdbaaf, 10, "R1 R8 R9 enc poked", "R3 R8 enc latency", 1'b0, 1'b1);
        run(K_ZERO, 128'h0, 1'b0,
            128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 10, "R1 enc zero", "R3 enc back-to-back", 1'b1, 1'b0);
        run(K_ZERO, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 1'b1,
            128'h0, 10, "R2 dec zero", "R4 dec after enc", 1'b0, 1'b0);
        run(K_STD, 128'h43b1cd7f598ece23881b00e3ed030688, 1'b1,
            128'h30c81c46a35ce411e5fbc1191a0a52ef, 20, "R2 R8 R9 dec poked", "R5 R8 dec new key", 1'b0, 1'b1);
        run(K_STD, 128'hf69f2445df4f9b17ad2b417be66c3710, 1'b0,
            128'h7b0c785e27e8ad3f8223207104725dd4, 10, "R1 enc back-to-back", "R3 enc latency", 1'b1, 1'b0);
        drain();

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk128("R10 block_o after second reset", block_o, 128'h0);
        chk_int("R10 done_o after second reset", int'(done_o), 0);
        rst_n = 1'b1;

        run(K_STD, 128'h7b0c785e27e8ad3f8223207104725dd4, 1'b1,
            128'hf69f2445df4f9b17ad2b417be66c3710, 20, "R2 dec after reset", "R10 R5 key forgotten", 1'b0, 1'b0);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule